// File: doc/BRIEF.md
# Paged Memory Window Translator

This block maps a host memory address onto a card address through a small set of programmable windows belonging to one socket. Each window is described by a first page, a last page and a card page offset, all counted in 4 KB pages. Each window also carries two flags: one asks for a 16-bit data path, and one steers the access to attribute memory instead of common memory. A shared control register switches each window on or off and picks between a fine and a coarse page decode.

Software programs the windows one byte at a time through a simple write port. The translation path is purely combinational. For the current host address it reports whether an enabled window claims it, the index of that window, the translated card address, the attribute/common select and the data width. When more than one enabled window matches, the lowest-numbered one is chosen.

Top module: `memWinXlate`

## Requirements
- R1: After reset every register reads as zero, so no window is enabled and `hit` is 0 for any host address.
- R2: Window i (0..3) owns the byte indexes 0x10+8*i up to 0x15+8*i. In ascending order these hold: first page bits 7:0; first page bits 11:8 in data bits 3:0; last page bits 7:0; last page bits 11:8; card offset bits 7:0; card offset bits 12:8 in data bits 4:0. A write takes effect from the clock edge on which `wrEn` is sampled high.
- R3: Byte index 0x06 is the control register. Data bits 3:0 enable windows 0..3, one bit each. A window whose bit is 0 never produces a hit.
- R4: When control bit 5 is 1 (fine decode), an enabled window hits when first page <= host address bits 23:12 <= last page. Both ends are inclusive.
- R5: When control bit 5 is 0 (coarse decode), only page bits 11:5 (host bits 23:17) are compared against the same bits of the first and last page. The lower five page bits are don't-care.
- R6: On a hit, `cardAddr` = (hostAddr + offset*4096) mod 2^25. The offset is the 13-bit value from R2, so the card page wraps modulo 2^13 and `cardAddr[11:0]` equals `hostAddr[11:0]`.
- R7: On a hit, `attrSel` equals bit 6 of the hitting window's offset-high byte (index 0x15+8*i); 1 means attribute memory.
- R8: On a hit, `wide16` equals bit 7 of the hitting window's first-page-high byte (index 0x11+8*i).
- R9: When several enabled windows match, `winIdx` and all card-side outputs come from the lowest-numbered matching window.
- R10: With no hit, `hit`, `winIdx`, `cardAddr`, `attrSel` and `wide16` are all 0.
- R11: Writes to any index not listed in R2 or R3 (for example 0x05, 0x07, 0x16, 0x17) change no translation result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register byte write strobe |
| wrIdx | input | 6 | Register byte index |
| wrData | input | 8 | Register byte data |
| hostAddr | input | 24 | Host memory address to translate |
| hit | output | 1 | An enabled window claims the address |
| winIdx | output | 2 | Index of the claiming window |
| cardAddr | output | 25 | Translated card address |
| attrSel | output | 1 | 1 = attribute memory, 0 = common memory |
| wide16 | output | 1 | 1 = 16-bit data path |

## Verification
Directed cases place host pages exactly on the first page, on the last page and one page outside each end; this separates an inclusive compare from an exclusive one. An offset large enough to carry past bit 24 shows whether the card page wraps modulo 2^25. Two overlapping windows, toggled through the enable bits, show whether the priority goes to the lowest index. A page that matches only in its upper seven bits shows the difference between fine and coarse decode. Random reprogramming, with host pages drawn near window edges, then compares every output against a bench model of the register map.

// File: rtl/memWinPkg.sv
package memWinPkg;
  localparam int NWIN        = 4;
  localparam int HOST_AW     = 24;
  localparam int CARD_AW     = 25;
  localparam int PAGE_SHIFT  = 12;
  localparam int IDX_W       = 6;
  localparam int CTRL_IDX    = 6;
  localparam int WIN_BASE    = 16;
  localparam int WIN_STRIDE  = 8;
  localparam int WIN_FIELDS  = 6;
  localparam int COARSE_LSB  = 5;
  localparam int PG_W        = HOST_AW - PAGE_SHIFT;
  localparam int OFF_W       = CARD_AW - PAGE_SHIFT;
  localparam int FLD_W       = $clog2(WIN_STRIDE);
  localparam int WIN_IDX_W   = $clog2(NWIN);

  typedef enum logic [FLD_W-1:0] {
    F_START_LO = 3'd0,
    F_START_HI = 3'd1,
    F_STOP_LO  = 3'd2,
    F_STOP_HI  = 3'd3,
    F_OFF_LO   = 3'd4,
    F_OFF_HI   = 3'd5
  } winField_e;

  typedef struct packed {
    logic            ctrlWr;
    logic [NWIN-1:0] winWr;
    winField_e       field;
    logic [7:0]      data;
  } regStrobe_t;
endpackage

// File: rtl/memWinCtrl.sv
module memWinCtrl
  import memWinPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [7:0]       wrData,
  output regStrobe_t       strobe
);
  logic [NWIN-1:0] winHit;

  for (genvar i = 0; i < NWIN; i++) begin : g_dec
    localparam int BASE = WIN_BASE + i * WIN_STRIDE;
    assign winHit[i] = wrEn && (int'(wrIdx) >= BASE) && (int'(wrIdx) < BASE + WIN_FIELDS);
  end

  always_comb begin
    strobe.ctrlWr = wrEn && (int'(wrIdx) == CTRL_IDX);
    strobe.winWr  = winHit;
    strobe.field  = winField_e'(wrIdx[FLD_W-1:0]);
    strobe.data   = wrData;
  end

  // R11: at most one register target per write, none when idle
  a_r11_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.ctrlWr, strobe.winWr}));
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> ({strobe.ctrlWr, strobe.winWr} == '0));
endmodule

// File: rtl/memWinPath.sv
module memWinPath
  import memWinPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strobe,
  input  logic [HOST_AW-1:0]   hostAddr,
  output logic                 hit,
  output logic [WIN_IDX_W-1:0] winIdx,
  output logic [CARD_AW-1:0]   cardAddr,
  output logic                 attrSel,
  output logic                 wide16
);
  logic [PG_W-1:0]  startPg [NWIN];
  logic [PG_W-1:0]  stopPg  [NWIN];
  logic [OFF_W-1:0] offPg   [NWIN];
  logic [NWIN-1:0]  wideFlag;
  logic [NWIN-1:0]  attrFlag;
  logic [NWIN-1:0]  enMask;
  logic             fineDec;
  logic [NWIN-1:0]  matchVec;
  logic [PG_W-1:0]  hostPg;

  assign hostPg = hostAddr[HOST_AW-1:PAGE_SHIFT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enMask  <= '0;
      fineDec <= 1'b0;
    end else if (strobe.ctrlWr) begin
      enMask  <= strobe.data[NWIN-1:0];
      fineDec <= strobe.data[5];
    end
  end

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rstN) begin
        startPg[i]  <= '0;
        stopPg[i]   <= '0;
        offPg[i]    <= '0;
        wideFlag[i] <= 1'b0;
        attrFlag[i] <= 1'b0;
      end else if (strobe.winWr[i]) begin
        case (strobe.field)
          F_START_LO: startPg[i][7:0] <= strobe.data;
          F_START_HI: begin
            startPg[i][PG_W-1:8] <= strobe.data[PG_W-9:0];
            wideFlag[i]          <= strobe.data[7];
          end
          F_STOP_LO:  stopPg[i][7:0] <= strobe.data;
          F_STOP_HI:  stopPg[i][PG_W-1:8] <= strobe.data[PG_W-9:0];
          F_OFF_LO:   offPg[i][7:0] <= strobe.data;
          F_OFF_HI: begin
            offPg[i][OFF_W-1:8] <= strobe.data[OFF_W-9:0];
            attrFlag[i]         <= strobe.data[6];
          end
          default: ;
        endcase
      end
    end

    logic fineHit, coarseHit;
    assign fineHit   = (hostPg >= startPg[i]) && (hostPg <= stopPg[i]);
    assign coarseHit = (hostPg[PG_W-1:COARSE_LSB] >= startPg[i][PG_W-1:COARSE_LSB]) &&
                       (hostPg[PG_W-1:COARSE_LSB] <= stopPg[i][PG_W-1:COARSE_LSB]);
    assign matchVec[i] = enMask[i] && (fineDec ? fineHit : coarseHit);
  end

  logic [WIN_IDX_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = NWIN - 1; i >= 0; i--)
      if (matchVec[i]) sel = WIN_IDX_W'(i);
  end

  logic [OFF_W-1:0] cardPg;
  assign cardPg = OFF_W'(hostPg) + offPg[sel];

  always_comb begin
    hit      = |matchVec;
    winIdx   = hit ? sel : '0;
    cardAddr = hit ? {cardPg, hostAddr[PAGE_SHIFT-1:0]} : '0;
    attrSel  = hit && attrFlag[sel];
    wide16   = hit && wideFlag[sel];
  end

  a_r3_only_enabled: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> enMask[winIdx]);
  a_r6_low_bits_pass: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (cardAddr[PAGE_SHIFT-1:0] == hostAddr[PAGE_SHIFT-1:0]));
  a_r9_lowest_wins: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> ((matchVec & ((NWIN'(1) << winIdx) - NWIN'(1))) == '0));
  a_r2_ctrl_lands: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ctrlWr |=> (enMask == $past(strobe.data[NWIN-1:0])));
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(!rstN) |-> !hit);
endmodule

// File: rtl/memWinXlate.sv
module memWinXlate
  import memWinPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [5:0]   wrIdx,
  input  logic [7:0]   wrData,
  input  logic [23:0]  hostAddr,
  output logic         hit,
  output logic [1:0]   winIdx,
  output logic [24:0]  cardAddr,
  output logic         attrSel,
  output logic         wide16
);
  regStrobe_t strobe;

  memWinCtrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrIdx  (wrIdx),
    .wrData (wrData),
    .strobe (strobe)
  );

  memWinPath u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .hostAddr (hostAddr),
    .hit      (hit),
    .winIdx   (winIdx),
    .cardAddr (cardAddr),
    .attrSel  (attrSel),
    .wide16   (wide16)
  );
endmodule

// File: tb/memWinXlate_tb.sv
`timescale 1ns/1ps
module memWinXlate_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  wrIdx = '0;
  logic [7:0]  wrData = '0;
  logic [23:0] hostAddr = '0;
  logic        hit;
  logic [1:0]  winIdx;
  logic [24:0] cardAddr;
  logic        attrSel, wide16;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] shadow [64];

  always #2 clk = ~clk;

  memWinXlate u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .hostAddr(hostAddr), .hit(hit), .winIdx(winIdx), .cardAddr(cardAddr),
    .attrSel(attrSel), .wide16(wide16)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h host=%h", req, act, exp, hostAddr);
    end
  endtask

  task automatic wr(input int idx, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 6'(idx); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    shadow[idx] = d;
  endtask

  task automatic progWin(input int w, input logic [11:0] st, input logic [11:0] sp,
                         input logic [12:0] off, input bit wide, input bit attr);
    int b = 16 + 8 * w;
    wr(b + 0, st[7:0]);
    wr(b + 1, {wide, 3'b000, st[11:8]});
    wr(b + 2, sp[7:0]);
    wr(b + 3, {4'b0000, sp[11:8]});
    wr(b + 4, off[7:0]);
    wr(b + 5, {1'b0, attr, 1'b0, off[12:8]});
  endtask

  function automatic void model(input logic [23:0] ha, output logic eh, output logic [1:0] ei,
                                output logic [24:0] ec, output logic ea, output logic ew);
    logic [11:0] pg, st, sp;
    logic [12:0] off, cp;
    bit m;
    eh = 0; ei = 0; ec = 0; ea = 0; ew = 0;
    pg = ha[23:12];
    for (int i = 3; i >= 0; i--) begin
      int b = 16 + 8 * i;
      st = {shadow[b+1][3:0], shadow[b]};
      sp = {shadow[b+3][3:0], shadow[b+2]};
      off = {shadow[b+5][4:0], shadow[b+4]};
      if (shadow[6][5]) m = (pg >= st) && (pg <= sp);
      else m = (pg[11:5] >= st[11:5]) && (pg[11:5] <= sp[11:5]);
      if (shadow[6][i] && m) begin
        eh = 1; ei = 2'(i);
        cp = {1'b0, pg} + off;
        ec = {cp, ha[11:0]};
        ea = shadow[b+5][6];
        ew = shadow[b+1][7];
      end
    end
  endfunction

  task automatic look(input logic [23:0] ha, input string rh, input string rc);
    logic eh, ea, ew; logic [1:0] ei; logic [24:0] ec;
    @(negedge clk);
    hostAddr = ha;
    #1;
    model(ha, eh, ei, ec, ea, ew);
    chk(rh, 32'(hit), 32'(eh));
    chk("R9", 32'(winIdx), 32'(ei));
    chk(rc, 32'(cardAddr), 32'(ec));
    chk("R7", 32'(attrSel), 32'(ea));
    chk("R8", 32'(wide16), 32'(ew));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) shadow[i] = 8'h00;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 / R10: reset state
    @(negedge clk); hostAddr = 24'h000123; #1;
    chk("R1", 32'(hit), 0);
    chk("R10", 32'(cardAddr), 0);

    // R2 / R4 / R6: basic window, fine decode
    progWin(0, 12'h100, 12'h10F, 13'h0010, 0, 0);
    wr(6, 8'h21);
    @(negedge clk); hostAddr = 24'h100ABC; #1;
    chk("R4", 32'(hit), 1);
    chk("R6", 32'(cardAddr), 32'h110ABC);
    look(24'h10FFFF, "R4", "R6");
    @(negedge clk); hostAddr = 24'h110000; #1;
    chk("R4", 32'(hit), 0);
    chk("R10", 32'(cardAddr), 0);
    @(negedge clk); hostAddr = 24'h0FFFFF; #1;
    chk("R4", 32'(hit), 0);

    // R3: disable window 0
    wr(6, 8'h20);
    @(negedge clk); hostAddr = 24'h100ABC; #1;
    chk("R3", 32'(hit), 0);
    wr(6, 8'h21);

    // R6: wrap modulo 2^25
    progWin(0, 12'h100, 12'h10F, 13'h1F00, 0, 0);
    @(negedge clk); hostAddr = 24'h10FABC; #1;
    chk("R6", 32'(cardAddr), 32'h000FABC);

    // R7 / R8: flags
    progWin(0, 12'h100, 12'h10F, 13'h0000, 1, 1);
    @(negedge clk); hostAddr = 24'h105000; #1;
    chk("R7", 32'(attrSel), 1);
    chk("R8", 32'(wide16), 1);

    // R9: overlapping windows
    progWin(1, 12'h104, 12'h200, 13'h0100, 0, 0);
    wr(6, 8'h23);
    @(negedge clk); hostAddr = 24'h105000; #1;
    chk("R9", 32'(winIdx), 0);
    chk("R9", 32'(cardAddr), 32'h105000);
    wr(6, 8'h22);
    @(negedge clk); hostAddr = 24'h105000; #1;
    chk("R9", 32'(winIdx), 1);
    chk("R9", 32'(cardAddr), 32'h205000);

    // R5: coarse decode
    progWin(2, 12'h300, 12'h300, 13'h0000, 0, 0);
    wr(6, 8'h24);
    @(negedge clk); hostAddr = 24'h31F000; #1;
    chk("R5", 32'(hit), 0);
    wr(6, 8'h04);
    @(negedge clk); hostAddr = 24'h31F000; #1;
    chk("R5", 32'(hit), 1);
    chk("R5", 32'(winIdx), 2);
    @(negedge clk); hostAddr = 24'h320000; #1;
    chk("R5", 32'(hit), 0);

    // R11: unmapped indexes change nothing
    wr(6, 8'h21);
    progWin(0, 12'h100, 12'h10F, 13'h0010, 0, 0);
    wr(5, 8'hFF); wr(7, 8'hFF); wr(8'h16, 8'hFF); wr(8'h17, 8'hFF); wr(8'h3F, 8'hFF);
    @(negedge clk); hostAddr = 24'h100ABC; #1;
    chk("R11", 32'(hit), 1);
    chk("R11", 32'(cardAddr), 32'h110ABC);
    chk("R11", 32'(attrSel), 0);
    chk("R11", 32'(wide16), 0);

    // random mix against the model
    for (int n = 0; n < 400; n++) begin
      int r = $urandom_range(0, 9);
      if (r == 0) begin
        logic [11:0] st = 12'($urandom);
        logic [11:0] ln = 12'($urandom_range(0, 63));
        progWin($urandom_range(0, 3), st, st + ln, 13'($urandom),
                1'($urandom), 1'($urandom));
      end else if (r == 1) begin
        wr(6, 8'($urandom) & 8'h2F);
      end else if (r == 2) begin
        wr($urandom_range(0, 63), 8'($urandom));
      end else begin
        int w = $urandom_range(0, 3);
        int b = 16 + 8 * w;
        logic [11:0] st = {shadow[b+1][3:0], shadow[b]};
        logic [11:0] pg = st + 12'($urandom_range(0, 80)) - 12'd8;
        look({pg, 12'($urandom)}, "R4", "R6");
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule